// File: doc/BRIEF.md
# Phase Resync Delay Timer

This block decides when a fractional-N synthesizer re-aligns its fractional accumulator phase after a channel change. Each time software writes one of the two channel registers, the block starts counting reference-clock cycles. When the count reaches a programmed 15-bit interval, it emits a single-cycle resync strobe. The strobe resets the accumulator phase so that the output returns to the same phase relationship with the reference every time the same channel is programmed again.

Delaying the strobe lets the loop settle close to its final frequency first, so a cycle slip during the locking transient cannot undo the alignment. A usual choice for the interval is a whole multiple of the fractional modulus that is at least the loop's lock time. For example, 3900 cycles of a 26 MHz reference is 150 µs. The feature is armed only when three separate control bits are all set. A busy flag reports that a timing run is in progress.

Top module: `resync_delay_timer`

## Requirements
- R1: The timer is armed only when `arm_bits` equals 3'b111, where bit 2, bit 1 and bit 0 carry control-word positions 15, 14 and 11. With any other pattern, channel writes are ignored and `busy` stays 0.
- R2: While armed, a strobe on either `wr_ch0` or `wr_ch1` that is sampled at a clock edge starts a timing run, and `busy` is 1 in the following cycle.
- R3: The interval is captured at the edge that starts a run. Changes to `delay_cycles` during the run do not move the strobe.
- R4: With a captured interval N, `resync_pulse` is high in the cycle that begins N clock edges after the edge that sampled the write. The timer resolution is one reference-clock cycle.
- R5: `resync_pulse` lasts exactly one cycle. `busy` is 0 from the edge that ends the pulse cycle, unless a new run starts at that edge.
- R6: A channel write sampled while a run is in progress restarts the count from zero with the interval presented at that write. The earlier deadline produces no strobe.
- R7: An interval of 0 makes `resync_pulse` high in the cycle directly after the edge that sampled the write.
- R8: If `arm_bits` is sampled different from 3'b111 while a run is in progress, the run is aborted: `busy` clears at that edge and no strobe follows.
- R9: While `rst_n` is 0, and in the first cycle after it, `busy` and `resync_pulse` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; one timer tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ch0 | input | 1 | Write strobe of the first channel register |
| wr_ch1 | input | 1 | Write strobe of the second channel register |
| arm_bits | input | 3 | Resync enable field; 3'b111 arms the timer |
| delay_cycles | input | 15 | Programmed delay in reference cycles |
| resync_pulse | output | 1 | One-cycle accumulator phase resync strobe |
| busy | output | 1 | A timing run is in progress |

## Verification
The strobe spacing is measured for intervals 0, 1, 5, 130, 260 and 3900, triggered alternately by each channel strobe. This separates an off-by-one in the count from a wrong trigger source, and the modulus multiples match real use. Each of the seven non-arming enable patterns is applied with a write, to show that no single bit or pair of bits arms the timer. Three more sequences are run: a rewrite in mid-run, an interval change in mid-run, and a disarm in mid-run. They tell restart apart from capture and from abort. A behavioural deadline model is compared with `busy` and `resync_pulse` on every cycle.

// File: rtl/resync_timer_pkg.sv
package resync_timer_pkg;
  localparam int ARM_W = 3;
  localparam logic [ARM_W-1:0] ARM_PATTERN = 3'b111;

  // The timer is armed only by the full pattern; a partial match disarms it.
  function automatic logic arm_ok(input logic [ARM_W-1:0] bits);
    return bits == ARM_PATTERN;
  endfunction
endpackage

// File: rtl/resync_arm_decode.sv
module resync_arm_decode
  import resync_timer_pkg::*;
#(
  parameter int NUM_WR = 2
) (
  input  logic [ARM_W-1:0]  arm_bits,
  input  logic [NUM_WR-1:0] wr_vec,
  output logic              enable,
  output logic              trig
);
  logic [NUM_WR:0] any_wr;

  assign any_wr[0] = 1'b0;
  for (genvar g = 0; g < NUM_WR; g++) begin : g_wr_or
    assign any_wr[g+1] = any_wr[g] | wr_vec[g];
  end

  assign enable = arm_ok(arm_bits);
  assign trig   = enable & any_wr[NUM_WR];
endmodule

// File: rtl/resync_counter.sv
module resync_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trig,
  input  logic [CNT_W-1:0] interval,
  output logic             busy,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             busy_q;

  function automatic logic reached(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] l);
    return c == l;
  endfunction

  assign busy = busy_q;
  assign hit  = busy_q & reached(cnt_q, lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (!enable) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= interval;
    end else if (hit) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4: the count advances by one on each idle cycle of a run
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !hit && !trig && enable) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: the count never passes the captured limit
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= lim_q));

  // R3: the captured limit holds while no new run starts
  p_hold_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !trig) |=> $stable(lim_q));
endmodule

// File: rtl/resync_delay_timer.sv
module resync_delay_timer
  import resync_timer_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             wr_ch0,
  input  logic             wr_ch1,
  input  logic [2:0]       arm_bits,
  input  logic [CNT_W-1:0] delay_cycles,
  output logic             resync_pulse,
  output logic             busy
);
  // Named internal events, exposed for the assertions below
  logic enable_w;
  logic trig_w;
  logic hit_w;
  logic busy_w;

  resync_arm_decode #(.NUM_WR(2)) u_arm (
    .arm_bits (arm_bits),
    .wr_vec   ({wr_ch1, wr_ch0}),
    .enable   (enable_w),
    .trig     (trig_w)
  );

  resync_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .enable   (enable_w),
    .trig     (trig_w),
    .interval (delay_cycles),
    .busy     (busy_w),
    .hit      (hit_w)
  );

  assign resync_pulse = hit_w;
  assign busy         = busy_w;

  // R2: an armed write starts a run
  p_start_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trig_w |=> busy);

  // R7: a zero interval fires in the very next cycle
  p_zero_fire_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (trig_w && delay_cycles == '0) |=> resync_pulse);

  // R5: the strobe is one cycle wide and ends the run
  p_single_pulse_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (resync_pulse && !trig_w) |=> (!resync_pulse && !busy));

  // R8 and R1: a disarmed timer is idle after the edge
  p_disarm_idle_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !enable_w |=> (!busy && !resync_pulse));

  // R9: the strobe is only seen while a run is active
  p_pulse_in_run_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    resync_pulse |-> busy);
endmodule

// File: tb/resync_delay_timer_tb_top.sv
`timescale 1ns/1ps
module resync_delay_timer_tb_top;
  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_ch0 = 1'b0;
  logic        wr_ch1 = 1'b0;
  logic [2:0]  arm_bits = 3'b000;
  logic [14:0] delay_cycles = '0;
  logic        resync_pulse;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_ref = ~clk_ref;

  resync_delay_timer dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .wr_ch0(wr_ch0), .wr_ch1(wr_ch1),
    .arm_bits(arm_bits), .delay_cycles(delay_cycles),
    .resync_pulse(resync_pulse), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural deadline model: the cycle index at which the strobe is due
  int  cyc = 0;
  int  deadline = 0;
  bit  pending = 0;
  always @(posedge clk_ref) begin
    cyc = cyc + 1;
    if (!rst_n) pending = 0;
    else begin
      if (pending && cyc > deadline) pending = 0;
      if (arm_bits != 3'b111) pending = 0;
      else if (wr_ch0 || wr_ch1) begin
        deadline = cyc + int'(delay_cycles);
        pending = 1;
      end
    end
  end

  always @(negedge clk_ref) begin
    if (rst_n && !done) begin
      check(busy == pending, "R4 busy vs model", busy, pending);
      check(resync_pulse == (pending && cyc == deadline), "R5 pulse vs model",
            resync_pulse, (pending && cyc == deadline));
    end
  end

  // Write, then count cycles until the strobe; the gap must equal N
  task automatic run_delay(input int n, input bit use1, input string req);
    int waited;
    @(negedge clk_ref);
    delay_cycles = 15'(n); wr_ch0 = !use1; wr_ch1 = use1;
    @(negedge clk_ref);
    wr_ch0 = 0; wr_ch1 = 0;
    waited = 0;
    while (!resync_pulse && waited < 40000) begin
      @(negedge clk_ref); waited++;
    end
    check(waited == n, req, waited, n);
    @(negedge clk_ref);
    check(!resync_pulse && !busy, "R5 single cycle, busy cleared", {resync_pulse, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_ref);
    check(!busy && !resync_pulse, "R9 reset state", {busy, resync_pulse}, 0);
    rst_n = 1;
    @(negedge clk_ref);
    check(!busy && !resync_pulse, "R9 after reset", {busy, resync_pulse}, 0);

    // R1: every pattern other than 3'b111 leaves the timer idle
    for (int p = 0; p < 7; p++) begin
      arm_bits = 3'(p); delay_cycles = 15'd2; wr_ch0 = 1;
      @(negedge clk_ref); wr_ch0 = 0;
      check(!busy, "R1 partial pattern ignored", busy, 0);
      repeat (3) @(negedge clk_ref);
      check(!resync_pulse && !busy, "R1 no strobe when disarmed", resync_pulse, 0);
    end
    arm_bits = 3'b111;

    // R2 and R7: either strobe starts a run, zero fires next cycle
    @(negedge clk_ref); delay_cycles = 0; wr_ch1 = 1;
    @(negedge clk_ref); wr_ch1 = 0;
    check(busy, "R2 busy after write", busy, 1);
    check(resync_pulse, "R7 zero interval", resync_pulse, 1);
    @(negedge clk_ref);

    run_delay(0, 0, "R7 zero spacing");
    run_delay(1, 1, "R4 spacing 1");
    run_delay(5, 0, "R4 spacing 5");
    run_delay(130, 1, "R4 spacing 130");
    run_delay(260, 0, "R4 spacing 260");
    run_delay(3900, 1, "R4 spacing 3900");

    // R3: interval change mid-run is not seen
    @(negedge clk_ref); delay_cycles = 15'd20; wr_ch0 = 1;
    @(negedge clk_ref); wr_ch0 = 0; delay_cycles = 15'd3;
    begin
      int w = 0;
      while (!resync_pulse && w < 100) begin @(negedge clk_ref); w++; end
      check(w == 20, "R3 captured interval", w, 20);
    end
    @(negedge clk_ref);

    // R6: rewrite mid-run restarts with the new interval
    @(negedge clk_ref); delay_cycles = 15'd10; wr_ch0 = 1;
    @(negedge clk_ref); wr_ch0 = 0;
    repeat (5) @(negedge clk_ref);
    delay_cycles = 15'd8; wr_ch1 = 1;
    @(negedge clk_ref); wr_ch1 = 0;
    begin
      int w = 0;
      while (!resync_pulse && w < 100) begin @(negedge clk_ref); w++; end
      check(w == 8, "R6 restart from zero", w, 8);
    end
    @(negedge clk_ref);

    // R8: disarm mid-run aborts without strobe
    @(negedge clk_ref); delay_cycles = 15'd12; wr_ch0 = 1;
    @(negedge clk_ref); wr_ch0 = 0;
    repeat (4) @(negedge clk_ref);
    arm_bits = 3'b011;
    @(negedge clk_ref);
    check(!busy, "R8 abort clears busy", busy, 0);
    arm_bits = 3'b111;
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk_ref); if (resync_pulse) seen++; end
      check(seen == 0, "R8 no strobe after abort", seen, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_ref);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule